// File: doc/BRIEF.md
# Iterative Byte Multiplier and Divider

This block multiplies or divides two unsigned byte operands, called A and B. Both results go back into the same pair. A pulse on `start` while the unit is idle captures the operands and the operation select. The unit then works one bit per clock. The multiplier is shift-and-add. The divider is restoring division. The unit raises `done` for one cycle when the results are ready. In that cycle the new A and B values and both flags are presented, each with its write enable, so the surrounding register file can take them in that same cycle.

A multiply writes the low byte of the product to A and the high byte to B. A divide writes the quotient to A and the remainder to B. The carry flag is cleared by every operation. The overflow flag means something different for each operation. For a multiply it reports that the product did not fit in one byte. For a divide it reports a zero divisor. A zero divisor skips the iterations entirely and leaves A and B unchanged.

Top module: `muldiv_seq`

## Requirements
- R1: With `op_div`=0 (multiply), when `done` is high, `{b_out,a_out}` equals the 16-bit unsigned product of the captured A and B, and `ab_we` is 1.
- R2: After a multiply, `ov_out` is 1 exactly when the high product byte (`b_out`) is nonzero.
- R3: With `op_div`=1 (divide) and a nonzero divisor, when `done` is high, `a_out` is the unsigned quotient A/B, `b_out` is the remainder A mod B, `ab_we` is 1 and `ov_out` is 0.
- R4: A divide whose divisor is zero raises `done` in the cycle right after the clock edge that captured `start`. In that cycle `ov_out` is 1, `ab_we` is 0, and `a_out`/`b_out` show the original A and B.
- R5: On every `done` cycle, `cy_out` is 0 and both `cy_we` and `ov_we` are 1. Outside `done` cycles all three write enables are 0.
- R6: For a multiply or a divide with a nonzero divisor, `done` is high in the cycle after the 9th rising edge counted from (and including) the edge that captured `start`. `done` lasts exactly one cycle.
- R7: `busy` is high from the cycle after the capturing edge through the `done` cycle, inclusive. It is low when the unit is idle.
- R8: A `start` seen while `busy` is high, including in the `done` cycle, is ignored. The running operation's results are unchanged, no extra `done` follows, and `busy` falls after the `done` cycle.
- R9: While reset is applied, `busy`, `done`, `ab_we`, `cy_we` and `ov_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken only when idle |
| op_div | input | 1 | Operation select: 0 multiply, 1 divide |
| a_in | input | 8 | Operand A (multiplicand or dividend) |
| b_in | input | 8 | Operand B (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| a_out | output | 8 | New A value |
| b_out | output | 8 | New B value |
| ab_we | output | 1 | Write enable for A and B |
| cy_out | output | 1 | Carry flag value |
| cy_we | output | 1 | Carry flag write enable |
| ov_out | output | 1 | Overflow flag value |
| ov_we | output | 1 | Overflow flag write enable |

## Verification
Two things can fall in the same cycle: the `done` strobe of a running operation and a new `start` request. The same applies to a `start` arriving in the middle of the iterations. The bench provokes both cases. It raises `start` with different operands and a different operation part-way through a run, and again exactly in the `done` cycle. It then judges the outcome in three ways. The scoreboard must receive the original operation's results. No unexpected `done` may appear. `busy` must be low in the cycle after the `done` cycle. A strided sweep of operands for both operations is checked against a reference model, covering latency, flags and write enables. That sweep includes every divisor value, so it contains the zero-divisor case.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } md_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic zero_div,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  md_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load    = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = zero_div ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        step   = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIN;
      end
      ST_FIN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_FIN);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_no_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
  parameter int W = 8
) (
  input  logic         op_div,
  input  logic [W-1:0] upper,
  input  logic [W-1:0] lower,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] upper_n,
  output logic [W-1:0] lower_n
);

  logic [W:0]   acc_sum;
  logic [W:0]   shifted;
  logic [W-1:0] trial;
  logic         fits;

  always_comb begin
    acc_sum = {1'b0, upper} + {1'b0, (lower[0] ? opnd : '0)};
    shifted = {upper, lower[W-1]};
    fits    = (shifted >= {1'b0, opnd});
    trial   = shifted[W-1:0] - opnd;
    if (op_div) begin
      upper_n = fits ? trial : shifted[W-1:0];
      lower_n = {lower[W-2:0], fits};
    end else begin
      upper_n = acc_sum[W:1];
      lower_n = {acc_sum[0], lower[W-1:1]};
    end
  end

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         busy,
  input  logic         op_div,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] upper_q,
  output logic [W-1:0] lower_q,
  output logic         op_q,
  output logic         zdiv_q
);

  logic [W-1:0] opnd_q;
  logic [W-1:0] upper_d, lower_d, upper_s, lower_s;
  logic         op_d, zdiv_d, reg_en;

  muldiv_step #(.W(W)) u_step (
    .op_div  (op_q),
    .upper   (upper_q),
    .lower   (lower_q),
    .opnd    (opnd_q),
    .upper_n (upper_s),
    .lower_n (lower_s)
  );

  always_comb begin
    reg_en  = load | step;
    op_d    = op_q;
    zdiv_d  = zdiv_q;
    upper_d = upper_s;
    lower_d = lower_s;
    if (load) begin
      op_d    = op_div;
      zdiv_d  = op_div && (b_in == '0);
      lower_d = a_in;
      upper_d = zdiv_d ? b_in : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      lower_q <= '0;
      opnd_q  <= '0;
      op_q    <= 1'b0;
      zdiv_q  <= 1'b0;
    end else if (reg_en) begin
      upper_q <= upper_d;
      lower_q <= lower_d;
      if (load) begin
        opnd_q <= b_in;
        op_q   <= op_d;
        zdiv_q <= zdiv_d;
      end
    end
  end

  assert_opnd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opnd_q) && $stable(op_q));

  assert_div_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q && !zdiv_q) |-> (upper_q < opnd_q));

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
  import muldiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_div,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         ab_we,
  output logic         cy_out,
  output logic         cy_we,
  output logic         ov_out,
  output logic         ov_we
);

  localparam int PW = 2 * W;

  logic [1:0]   rst_sync_q;
  logic         rst_int_n;
  logic         load, step, op_q, zdiv_q;
  logic [W-1:0] upper_q, lower_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .zero_div (op_div && (b_in == '0)),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done)
  );

  muldiv_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .step    (step),
    .busy    (busy),
    .op_div  (op_div),
    .a_in    (a_in),
    .b_in    (b_in),
    .upper_q (upper_q),
    .lower_q (lower_q),
    .op_q    (op_q),
    .zdiv_q  (zdiv_q)
  );

  assign a_out  = lower_q;
  assign b_out  = upper_q;
  assign ab_we  = done && !zdiv_q;
  assign cy_out = 1'b0;
  assign cy_we  = done;
  assign ov_we  = done;
  assign ov_out = op_q ? zdiv_q : (upper_q != '0);

  // Operand shadow used only by the checks below
  logic [W-1:0] cap_a, cap_b;
  logic         cap_div;
  logic [PW-1:0] cap_prod, div_back;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      cap_div <= 1'b0;
    end else if (start && !busy) begin
      cap_a   <= a_in;
      cap_b   <= b_in;
      cap_div <= op_div;
    end
  end

  assign cap_prod = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};
  assign div_back = {{W{1'b0}}, a_out} * {{W{1'b0}}, cap_b} + {{W{1'b0}}, b_out};

  assert_mul_product_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !cap_div) |-> ({b_out, a_out} == cap_prod) && ab_we);

  assert_mul_overflow_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !cap_div) |-> (ov_out == (cap_prod[PW-1:W] != '0)));

  assert_div_result_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && cap_div && cap_b != '0) |->
      (div_back == {{W{1'b0}}, cap_a}) && (b_out < cap_b) && !ov_out && ab_we);

  assert_div_zero_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && cap_div && cap_b == '0) |->
      ov_out && !ab_we && (a_out == cap_a) && (b_out == cap_b));

  assert_flags_written_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!cy_out && cy_we && ov_we));

  assert_zero_div_fast_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy && op_div && b_in == '0) |=> done);

endmodule

// File: tb/sim_muldiv_seq.sv
`timescale 1ns/100ps
module sim_muldiv_seq;

  localparam int W     = 8;
  localparam int LIMIT = 190000;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ov;
    logic         we;
    int           lat;
    int           t0;
    logic         is_div;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start, op_div;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         busy, done, ab_we, cy_out, cy_we, ov_out, ov_we;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  muldiv_seq #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .a_in(a_in), .b_in(b_in), .busy(busy), .done(done),
    .a_out(a_out), .b_out(b_out), .ab_we(ab_we),
    .cy_out(cy_out), .cy_we(cy_we), .ov_out(ov_out), .ov_we(ov_we)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic exp_t model(input logic dv, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    logic [2*W-1:0] p;
    e.is_div = dv;
    if (!dv) begin
      p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
      e.a = p[W-1:0]; e.b = p[2*W-1:W];
      e.ov = (p[2*W-1:W] != 0); e.we = 1'b1; e.lat = 9;
    end else if (b == 0) begin
      e.a = a; e.b = b; e.ov = 1'b1; e.we = 1'b0; e.lat = 1;
    end else begin
      e.a = a / b; e.b = a % b; e.ov = 1'b0; e.we = 1'b1; e.lat = 9;
    end
    return e;
  endfunction

  // driver: launches one operation and pushes its expected result
  task automatic launch(input logic dv, input logic [W-1:0] a, input logic [W-1:0] b);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; op_div = dv; a_in = a; b_in = b;
    e = model(dv, a, b);
    e.t0 = cyc;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = b + 8'd3; op_div = ~dv;
    chk(busy == 1'b1, "R7 busy after start", busy, 1);
  endtask

  // monitor: compares every done against the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !done) begin
        chk(!ab_we && !cy_we && !ov_we, "R5 enables idle", {ab_we, cy_we, ov_we}, 0);
      end
      if (rst_n && done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          exp_t e;
          string tg;
          e = sb.pop_front();
          tg = !e.is_div ? "R1 mul" : (e.we ? "R3 div" : "R4 div0");
          chk(a_out == e.a, {tg, " a_out"}, a_out, e.a);
          chk(b_out == e.b, {tg, " b_out"}, b_out, e.b);
          chk(ab_we == e.we, {tg, " ab_we"}, ab_we, e.we);
          chk(ov_out == e.ov, !e.is_div ? "R2 ov" : (e.we ? "R3 ov" : "R4 ov"), ov_out, e.ov);
          chk(!cy_out && cy_we && ov_we, "R5 flags", {cy_out, cy_we, ov_we}, 3'b011);
          chk(cyc - e.t0 == e.lat, e.lat == 1 ? "R4 latency" : "R6 latency", cyc - e.t0, e.lat);
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc >= LIMIT);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_div = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ab_we && !cy_we && !ov_we, "R9 reset outputs",
        {busy, done, ab_we, cy_we, ov_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done, "R9 idle after release", {busy, done}, 0);

    // R6 done pulse width and R7 busy span on one multiply
    launch(1'b0, 8'd200, 8'd3);
    repeat (7) @(negedge clk);
    chk(busy && !done, "R7 busy mid-run", {busy, done}, 2);
    @(negedge clk);
    chk(done && busy, "R6 done with busy", {done, busy}, 3);
    @(negedge clk);
    chk(!done && !busy, "R6 single-cycle done", {done, busy}, 0);

    // R8: start during iterations and during the done cycle
    launch(1'b1, 8'd251, 8'd7);
    repeat (2) @(negedge clk);
    start = 1'b1; op_div = 1'b0; a_in = 8'd9; b_in = 8'd9;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    start = 1'b1; op_div = 1'b1; a_in = 8'd100; b_in = 8'd0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R8 done-cycle start ignored", busy, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && sb.size() == 0, "R8 no relaunch", {busy, sb.size() != 0}, 0);

    // corner cases
    launch(1'b0, 8'd255, 8'd255);
    launch(1'b1, 8'd0, 8'd0);
    launch(1'b1, 8'd255, 8'd1);
    launch(1'b1, 8'd5, 8'd255);

    // strided sweep of A against every B, both operations
    for (int ai = 0; ai < 256; ai += 17) begin
      for (int bi = 0; bi < 256; bi++) begin
        launch(1'b0, 8'(ai), 8'(bi));
        launch(1'b1, 8'(ai), 8'(bi));
      end
    end

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R6 all results delivered", sb.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule